// File: doc/BRIEF.md
# Sync Event Source Conditioner

This block takes three asynchronous reference inputs (an external sync pin, a low-speed reference clock and a USB start-of-frame pulse) and turns the chosen one into a SYNC event. The event is a pulse one system clock wide. Software picks the source, the active edge and a power-of-two prescale factor. Only every 2^n-th active edge of the chosen source produces an event.

Each event is also the reload strobe for a downstream frequency error counter. The block holds the reload value and the frequency error limit that software programs, and it drives both out beside the strobe.

Configuration is written through one write strobe that carries every field at once. A write that alters the source, the polarity or the divider restarts the prescaler, so no event can come from a partial count taken under the old setting.

Top module: `sync_event_conditioner`

## Requirements
- R1: After the active-low synchronous reset, the source is the start-of-frame input (code 2), the active edge is rising, the divider is 0, the reload and limit outputs carry their reset parameter values, and `evt_stb` is low.
- R2: Source code 0 selects `sync_pin`, code 1 selects `lsref_clk` and code 2 selects `sof_pulse`. Edges on the inputs that are not selected produce no event.
- R3: Source code 3 is reserved, and edges on any input produce no event while it is selected.
- R4: With polarity 0 only a low-to-high transition of the selected input counts as an active edge. With polarity 1 only a high-to-low transition counts.
- R5: With divider value n (0 to 7), exactly one event is produced for every 2^n active edges counted after a prescaler clear. The event falls on the 2^n-th edge.
- R6: `evt_stb` is high for exactly one clock per event, and no event is lost when the prescaler wraps.
- R7: A write in which the source, polarity or divider differs from the held value clears the prescaler count. An active edge that falls in the cycle of that write is not counted.
- R8: An input transition made between clock edges shows on `evt_stb` after the third following rising clock edge: two synchroniser stages, then the event register.
- R9: `reload_val` and `limit_val` show the values from the last configuration write.
- R10: A write that leaves source, polarity and divider unchanged keeps the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Source select to write |
| cfg_pol | input | 1 | Edge polarity to write (0 rising, 1 falling) |
| cfg_div | input | DIV_W | Prescale exponent to write |
| cfg_reload | input | RLD_W | Reload value to write |
| cfg_limit | input | LIM_W | Error limit to write |
| sync_pin | input | 1 | External sync input, asynchronous |
| lsref_clk | input | 1 | Low-speed reference clock, asynchronous |
| sof_pulse | input | 1 | USB start-of-frame pulse, asynchronous |
| evt_stb | output | 1 | SYNC event and reload strobe, one cycle |
| reload_val | output | RLD_W | Reload value for the error counter |
| limit_val | output | LIM_W | Frequency error limit |

## Verification
On every cycle the assertions check four things: the reset state of the configuration, that the event strobe is never two cycles wide, that the reserved source stays silent, and that the prescale count stays below 2^n and returns to zero after a changing write. Other behaviours show only over the bench's scenarios. These are the exact event count for a given number of edges at each divider value, the choice of rising or falling edge, that unselected inputs have no effect, the three-edge latency, and that a write with an unchanged setting keeps a partial count.

// File: rtl/sync_event_conditioner.sv
module sync_event_conditioner #(
  parameter int RLD_W = 16,
  parameter int LIM_W = 16,
  parameter int DIV_W = 3,
  parameter logic [RLD_W-1:0] RLD_RST = RLD_W'(47999),
  parameter logic [LIM_W-1:0] LIM_RST = LIM_W'(34)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_src,
  input  logic             cfg_pol,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [RLD_W-1:0] cfg_reload,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             sync_pin,
  input  logic             lsref_clk,
  input  logic             sof_pulse,
  output logic             evt_stb,
  output logic [RLD_W-1:0] reload_val,
  output logic [LIM_W-1:0] limit_val
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [2:0] s1, s2, s3;
  logic [1:0] src_q;
  logic       pol_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt;
  logic       hit;

  wire [2:0] rise = s2 & ~s3;
  wire [2:0] fall = ~s2 & s3;
  wire [2:0] act  = pol_q ? fall : rise;
  wire [CNT_W-1:0] mask = ~({CNT_W{1'b1}} << div_q);
  wire term = (cnt == mask);
  wire cfg_chg = cfg_we && ({cfg_src, cfg_pol, cfg_div} != {src_q, pol_q, div_q});

  always_comb begin
    case (src_q)
      2'd0:    hit = act[0];
      2'd1:    hit = act[1];
      2'd2:    hit = act[2];
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= {sof_pulse, lsref_clk, sync_pin};
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q      <= 2'd2;
      pol_q      <= 1'b0;
      div_q      <= '0;
      reload_val <= RLD_RST;
      limit_val  <= LIM_RST;
      cnt        <= '0;
      evt_stb    <= 1'b0;
    end else begin
      evt_stb <= hit && term && !cfg_chg;
      if (cfg_we) begin
        src_q      <= cfg_src;
        pol_q      <= cfg_pol;
        div_q      <= cfg_div;
        reload_val <= cfg_reload;
        limit_val  <= cfg_limit;
      end
      if (cfg_chg)  cnt <= '0;
      else if (hit) cnt <= term ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sync_event_conditioner_chk.sv
module sync_event_conditioner_chk #(
  parameter int DIV_W = 3,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_stb,
  input logic [1:0]       src_q,
  input logic [DIV_W-1:0] div_q,
  input logic [CNT_W-1:0] cnt,
  input logic             cfg_chg
);
  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (src_q == 2'd2 && div_q == '0 && !evt_stb && cnt == '0));

  assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |=> !evt_stb);

  assert_reserved_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_q) == 2'd3) |-> !evt_stb);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} < ((CNT_W+1)'(1) << div_q)));

  assert_clear_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_chg) |-> (cnt == '0));
endmodule

bind sync_event_conditioner sync_event_conditioner_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .src_q(src_q),
  .div_q(div_q), .cnt(cnt), .cfg_chg(cfg_chg));

// File: tb/test_sync_event_conditioner.sv
module test_sync_event_conditioner;
  localparam int RLD_W = 16;
  localparam int LIM_W = 16;
  localparam int DIV_W = 3;
  localparam logic [RLD_W-1:0] RLD_RST = 16'd47999;
  localparam logic [LIM_W-1:0] LIM_RST = 16'd34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_src = 2'd2;
  logic cfg_pol = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [RLD_W-1:0] cfg_reload = '0;
  logic [LIM_W-1:0] cfg_limit = '0;
  logic [2:0] ins = '0;
  logic evt_stb;
  logic [RLD_W-1:0] reload_val;
  logic [LIM_W-1:0] limit_val;

  int checks = 0;
  int errors = 0;
  int ev = 0;
  int hi = 0;
  logic evt_d = 1'b0;

  always #5 clk = ~clk;

  sync_event_conditioner #(.RLD_W(RLD_W), .LIM_W(LIM_W), .DIV_W(DIV_W),
    .RLD_RST(RLD_RST), .LIM_RST(LIM_RST)) i_sync_event_conditioner (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_pol(cfg_pol), .cfg_div(cfg_div), .cfg_reload(cfg_reload),
    .cfg_limit(cfg_limit), .sync_pin(ins[0]), .lsref_clk(ins[1]),
    .sof_pulse(ins[2]), .evt_stb(evt_stb), .reload_val(reload_val),
    .limit_val(limit_val));

  always @(negedge clk) begin
    if (evt_stb) hi++;
    if (evt_stb && !evt_d) ev++;
    evt_d <= evt_stb;
  end

  typedef struct packed {
    logic [1:0] src;
    logic       pol;
    logic [2:0] div;
    logic [2:0] mask;
    logic [7:0] n;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd2, 1'b0, 3'd0, 3'b100, 8'd5,   8'd5},
    '{2'd0, 1'b0, 3'd0, 3'b001, 8'd3,   8'd3},
    '{2'd1, 1'b1, 3'd0, 3'b010, 8'd4,   8'd4},
    '{2'd0, 1'b0, 3'd0, 3'b110, 8'd4,   8'd0},
    '{2'd3, 1'b0, 3'd0, 3'b111, 8'd4,   8'd0},
    '{2'd1, 1'b0, 3'd1, 3'b010, 8'd6,   8'd3},
    '{2'd2, 1'b0, 3'd3, 3'b100, 8'd16,  8'd2},
    '{2'd0, 1'b1, 3'd2, 3'b001, 8'd9,   8'd2},
    '{2'd1, 1'b0, 3'd7, 3'b010, 8'd128, 8'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ins = '0;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic p, input logic [2:0] d,
                    input logic [15:0] r, input logic [15:0] l);
    cfg_src = s; cfg_pol = p; cfg_div = d; cfg_reload = r; cfg_limit = l;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] m);
    ins = ins | m;
    repeat (4) @(negedge clk);
    ins = ins & ~m;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    do_reset();
    // R1 reset state
    check("R1 evt_stb after reset", int'(evt_stb), 0);
    check("R1 reload_val default", int'(reload_val), int'(RLD_RST));
    check("R1 limit_val default", int'(limit_val), int'(LIM_RST));
    e0 = ev;
    pulse(3'b001);
    check("R1 default source ignores sync_pin", ev - e0, 0);
    pulse(3'b100);
    check("R1 default start-of-frame divide-by-1", ev - e0, 1);

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < 9; i++) begin
      do_reset();
      wr(VECS[i].src, VECS[i].pol, VECS[i].div, 16'd0, 16'd0);
      e0 = ev;
      for (int k = 0; k < int'(VECS[i].n); k++) pulse(VECS[i].mask);
      check($sformatf("R2 R3 R4 R5 vector %0d events", i), ev - e0, int'(VECS[i].exp));
    end

    // R8 latency and R6 width
    do_reset();
    ins[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R8 no event after two edges", int'(evt_stb), 0);
    @(posedge clk); @(negedge clk);
    check("R8 event after third edge", int'(evt_stb), 1);
    @(posedge clk); @(negedge clk);
    check("R6 event one cycle wide", int'(evt_stb), 0);
    ins[2] = 1'b0;
    repeat (4) @(negedge clk);

    // R4 edge choice
    do_reset();
    wr(2'd0, 1'b0, 3'd0, 16'd0, 16'd0);
    e0 = ev;
    ins[0] = 1'b1; repeat (5) @(negedge clk);
    check("R4 rising polarity on rise", ev - e0, 1);
    ins[0] = 1'b0; repeat (5) @(negedge clk);
    check("R4 rising polarity on fall", ev - e0, 1);
    wr(2'd0, 1'b1, 3'd0, 16'd0, 16'd0);
    e0 = ev;
    ins[0] = 1'b1; repeat (5) @(negedge clk);
    check("R4 falling polarity on rise", ev - e0, 0);
    ins[0] = 1'b0; repeat (5) @(negedge clk);
    check("R4 falling polarity on fall", ev - e0, 1);

    // R7 changing write clears the partial count
    do_reset();
    wr(2'd0, 1'b0, 3'd2, 16'd0, 16'd0);
    e0 = ev;
    for (int k = 0; k < 3; k++) pulse(3'b001);
    check("R7 partial count no event", ev - e0, 0);
    wr(2'd0, 1'b0, 3'd1, 16'd0, 16'd0);
    pulse(3'b001);
    check("R7 first edge after clear", ev - e0, 0);
    pulse(3'b001);
    check("R7 second edge after clear", ev - e0, 1);

    // R10 unchanged write keeps count, R9 pass-through
    do_reset();
    wr(2'd0, 1'b0, 3'd1, 16'h1234, 16'h0056);
    check("R9 reload_val written", int'(reload_val), 16'h1234);
    check("R9 limit_val written", int'(limit_val), 16'h0056);
    e0 = ev;
    pulse(3'b001);
    wr(2'd0, 1'b0, 3'd1, 16'hBEEF, 16'h0077);
    check("R9 reload_val rewritten", int'(reload_val), 16'hBEEF);
    check("R9 limit_val rewritten", int'(limit_val), 16'h0077);
    pulse(3'b001);
    check("R10 count kept across same-setting write", ev - e0, 1);

    check("R6 high cycles equal events", hi, ev);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule